// File: doc/BRIEF.md
# Floating-Point Register Pending-Write Scoreboard

This block sits beside the decode stage of a pipeline whose floating-point units take different numbers of cycles. For each of 32 floating-point registers it keeps one bit that says whether the stored value is current. When a value is not current, a write to that register is still in flight.

Each cycle, decode offers an instruction to the block. The instruction names up to two sources and an optional destination, and the block answers with a stall decision. An instruction that is not stalled and writes a register clears that register's bit. The issue also returns a short sequence tag, which travels with the instruction down its functional unit.

When a unit finishes, it presents the register number and the tag on the completion port. The block replies with the write enable for that writeback. If a younger write to the same register has issued since, the older result must not land, so its write enable is forced low and the bit stays clear. Register data and the bypass multiplexers live elsewhere. The bypass logic only reports, for each source, whether it can supply the value.

Top module: `fp_ready_scoreboard`

## Requirements
- R1: After reset every register, register 0 included, is marked ready. An instruction reading any register is not stalled, and every per-register tag is 0.
- R2: An instruction issues when `issue_req` is 1 and `stall` is 0. If it has `dst_wr` set, the ready bit of `dst` is cleared from the next cycle on, so a later reader of that register without bypass stalls.
- R3: A completion whose `cmp_tag` equals the latest tag issued to `cmp_reg` drives `cmp_we` to 1 in the same cycle. From the next cycle on, the register is ready.
- R4: `stall` is 1 exactly when `issue_req` is 1 and, for source A or source B, the source is marked used, its register is not ready, and its bypass flag is 0. A source whose used flag is 0 never causes a stall.
- R5: A bypass flag of 1 on a source removes that source's stall, whatever its ready bit.
- R6: A completion whose tag differs from the latest tag issued to that register drives `cmp_we` to 0 and leaves the ready bit unchanged. This suppresses the older of two overlapping writes to one register.
- R7: A completion and an issue may target the same register in one cycle. The completion's `cmp_we` is then judged against the tag held before the issue. The ready bit ends at 0, because the issue wins.
- R8: `issue_tag` is the register's latest tag plus one, modulo 2^TAGW. An issue with `dst_wr` set stores this value as the register's new latest tag. A stalled instruction changes no state.
- R9: An issued instruction with `dst_wr` at 0 leaves every ready bit and tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_req | input | 1 | Decode holds an instruction that wants to issue |
| src_a | input | 5 | Source A register number |
| src_a_used | input | 1 | Source A is read by the instruction |
| src_a_byp | input | 1 | Source A value is available on a bypass path |
| src_b | input | 5 | Source B register number |
| src_b_used | input | 1 | Source B is read by the instruction |
| src_b_byp | input | 1 | Source B value is available on a bypass path |
| dst | input | 5 | Destination register number |
| dst_wr | input | 1 | Instruction writes `dst` |
| cmp_valid | input | 1 | A functional unit is writing back this cycle |
| cmp_reg | input | 5 | Register being written back |
| cmp_tag | input | 3 | Tag the completing instruction received at issue |
| stall | output | 1 | Hold the instruction in decode |
| issue_tag | output | 3 | Tag for the issuing write |
| cmp_we | output | 1 | Write enable for the completing writeback |

## Verification
The properties assume that fewer than 2^TAGW writes to any one register are in flight at once. They also assume that a completion only carries a tag that was actually handed out for that register. Without these conditions a stale tag could alias the latest one.

The stimulus keeps within these bounds. The wrap test issues more writes to one register than the tag range holds, but it completes only the newest of them. Every other completion uses a tag taken from a prior issue.

// File: rtl/fp_ready_scoreboard.sv
module fp_ready_scoreboard #(
  parameter int NREG = 32,
  parameter int TAGW = 3,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_req,
  input  logic [RW-1:0]   src_a,
  input  logic            src_a_used,
  input  logic            src_a_byp,
  input  logic [RW-1:0]   src_b,
  input  logic            src_b_used,
  input  logic            src_b_byp,
  input  logic [RW-1:0]   dst,
  input  logic            dst_wr,
  input  logic            cmp_valid,
  input  logic [RW-1:0]   cmp_reg,
  input  logic [TAGW-1:0] cmp_tag,
  output logic            stall,
  output logic [TAGW-1:0] issue_tag,
  output logic            cmp_we
);

  logic [NREG-1:0] ready_q;
  logic [TAGW-1:0] tag_q [NREG];

  logic a_wait, b_wait, fire;

  assign a_wait    = src_a_used && !ready_q[src_a] && !src_a_byp;
  assign b_wait    = src_b_used && !ready_q[src_b] && !src_b_byp;
  assign stall     = issue_req && (a_wait || b_wait);
  assign fire      = issue_req && !stall && dst_wr;
  assign issue_tag = tag_q[dst] + TAGW'(1);
  assign cmp_we    = cmp_valid && (cmp_tag == tag_q[cmp_reg]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= '1;
      for (int i = 0; i < NREG; i++) tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (fire && dst == RW'(i)) begin
          ready_q[i] <= 1'b0;
          tag_q[i]   <= issue_tag;
        end else if (cmp_we && cmp_reg == RW'(i)) begin
          ready_q[i] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fp_ready_scoreboard_chk.sv
module fp_ready_scoreboard_chk #(
  parameter int NREG = 32,
  parameter int TAGW = 3,
  localparam int RW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_req,
  input logic [RW-1:0]   src_a,
  input logic            src_a_used,
  input logic            src_a_byp,
  input logic [RW-1:0]   src_b,
  input logic            src_b_used,
  input logic            src_b_byp,
  input logic [RW-1:0]   dst,
  input logic            dst_wr,
  input logic            cmp_valid,
  input logic [RW-1:0]   cmp_reg,
  input logic [TAGW-1:0] cmp_tag,
  input logic            stall,
  input logic [TAGW-1:0] issue_tag,
  input logic            cmp_we,
  input logic [NREG-1:0] ready_q
);

  logic go;
  assign go = issue_req && !stall && dst_wr;

  // R4
  stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> issue_req);

  // R5
  bypass_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_req && (!src_a_used || src_a_byp) && (!src_b_used || src_b_byp)) |-> !stall);

  // R6
  we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |-> cmp_valid);

  // R2
  issue_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !ready_q[$past(dst)]);

  // R3
  complete_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && !(go && dst == cmp_reg)) |=> ready_q[$past(cmp_reg)]);

  // R6
  stale_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_we && !(go && dst == cmp_reg))
      |=> ready_q[$past(cmp_reg)] == $past(ready_q[cmp_reg]));

  // R7
  issue_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmp_we && dst == cmp_reg) |=> !ready_q[$past(dst)]);

endmodule

bind fp_ready_scoreboard fp_ready_scoreboard_chk #(.NREG(NREG), .TAGW(TAGW)) u_chk (.*);

// File: tb/test_fp_ready_scoreboard.sv
`timescale 1ns/1ps
module test_fp_ready_scoreboard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_req, src_a_used, src_a_byp, src_b_used, src_b_byp, dst_wr, cmp_valid;
  logic [4:0] src_a, src_b, dst, cmp_reg;
  logic [2:0] cmp_tag;
  logic stall, cmp_we;
  logic [2:0] issue_tag;

  int checks = 0, failures = 0;
  bit done = 0;
  bit er [32];
  int et [32];

  always #4 clk = ~clk;

  fp_ready_scoreboard i_fp_ready_scoreboard (.*);

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic idle();
    issue_req = 0; src_a = 0; src_a_used = 0; src_a_byp = 0;
    src_b = 0; src_b_used = 0; src_b_byp = 0;
    dst = 0; dst_wr = 0; cmp_valid = 0; cmp_reg = 0; cmp_tag = 0;
  endtask

  task automatic tick(input string rq);
    bit aw, bw, es, ew, fire;
    int etag;
    #1;
    aw = src_a_used && !er[src_a] && !src_a_byp;
    bw = src_b_used && !er[src_b] && !src_b_byp;
    es = issue_req && (aw || bw);
    etag = (et[dst] + 1) % 8;
    ew = cmp_valid && (int'(cmp_tag) == et[cmp_reg]);
    fire = issue_req && !es && dst_wr;
    chk({rq, " stall"}, int'(stall), int'(es));
    chk({rq, " cmp_we"}, int'(cmp_we), int'(ew));
    if (issue_req && dst_wr) chk({rq, " issue_tag"}, int'(issue_tag), etag);
    @(posedge clk);
    if (ew && !(fire && dst == cmp_reg)) er[cmp_reg] = 1;
    if (fire) begin er[dst] = 0; et[dst] = etag; end
    @(negedge clk);
    idle();
  endtask

  task automatic probe(input int r, input string rq);
    issue_req = 1; src_a = 5'(r); src_a_used = 1;
    tick(rq);
  endtask

  task automatic wr(input int r, input string rq);
    issue_req = 1; dst = 5'(r); dst_wr = 1;
    tick(rq);
  endtask

  task automatic done_cmp(input int r, input int t, input string rq);
    cmp_valid = 1; cmp_reg = 5'(r); cmp_tag = 3'(t);
    tick(rq);
  endtask

  initial begin
    #(8ns * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    for (int i = 0; i < 32; i++) begin er[i] = 1; et[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: every register ready after reset, tag starts at 0
    for (int r = 0; r < 32; r++) begin
      issue_req = 1; src_b = 5'(r); src_b_used = 1; src_a = 5'(31 - r); src_a_used = 1;
      tick("R1");
    end
    for (int r = 0; r < 32; r++) begin
      done_cmp(r, 0, "R1");
    end

    // R2, R3, R9: write, probe, no-write issue, complete, probe
    for (int r = 0; r < 32; r++) begin
      wr(r, "R2");
      probe(r, "R2");
      issue_req = 1; dst = 5'(r); dst_wr = 0; tick("R9");
      probe(r, "R9");
      done_cmp(r, et[r], "R3");
      probe(r, "R3");
    end

    // R4, R5: exhaustive source combinations over a pending and a ready register
    wr(5, "R4");
    for (int m = 0; m < 64; m++) begin
      issue_req = 1;
      src_a = m[0] ? 5'd5 : 5'd9; src_b = m[1] ? 5'd5 : 5'd9;
      src_a_used = m[2]; src_a_byp = m[3]; src_b_used = m[4]; src_b_byp = m[5];
      tick(m[3] || m[5] ? "R5" : "R4");
    end
    // R4: stalled writer must not issue (R8 no state change)
    issue_req = 1; src_a = 5; src_a_used = 1; dst = 20; dst_wr = 1; tick("R8");
    probe(20, "R8");
    done_cmp(5, et[5], "R3");

    // R6: overlapping writes to one register
    wr(7, "R6");
    begin
      int t_old;
      t_old = et[7];
      wr(7, "R6");
      done_cmp(7, t_old, "R6");
      probe(7, "R6");
      done_cmp(7, et[7], "R6");
      probe(7, "R6");
    end

    // R7: completion and new issue hit one register together
    wr(3, "R7");
    issue_req = 1; dst = 3; dst_wr = 1; cmp_valid = 1; cmp_reg = 3; cmp_tag = 3'(et[3]);
    tick("R7");
    probe(3, "R7");
    done_cmp(3, et[3], "R7");
    probe(3, "R7");

    // R8: tag sequence wraps modulo 8
    for (int k = 0; k < 10; k++) wr(12, "R8");
    done_cmp(12, et[12], "R8");
    probe(12, "R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule